// File: doc/BRIEF.md
# Power-Management Event and Control Register Block

This block holds the three 16-bit power-management registers a guest or simple platform exposes to its operating system: a status register, an enable register and a control register. The registers are reached over a narrow I/O port that carries a byte offset, an access size of one or two bytes, write data and separate read and write strobes. Read data is returned on the clock edge after the strobe.

Software asks for a sleep state by writing the control register with its sleep-enable bit set. The block decodes the sleep-type field of that write into a one-cycle suspend pulse or a one-cycle power-off pulse for the platform logic. A compile-time direct mode turns every sleep request into power-off. A resume-imminent input from the platform sets the wake flag in the status register. Accesses that are malformed, or that fall outside the register map, are rejected and reported with a one-cycle pulse.

Top module: `pm1_regblk`

## Requirements
- R1: After reset all three registers read as 0, and `rdata`, `bad_access`, `suspend_pulse`, `poweroff_pulse` and `sleep_type_err` are 0.
- R2: Offsets 0–1 address status, offsets 2–3 address enable and offsets 4–5 address control, little-endian (the even offset is bits 7:0). `io_size` gives the byte count (1 or 2). A valid read returns the addressed bytes right-aligned in `rdata` on the edge after `io_rd`, with bits above the access width at 0. `rdata` is 0 in every other cycle.
- R3: An access with `io_size` of 0 or 3, an access whose last byte lies past the end of its register (offset odd with size 2), or an access at offset 6 or higher changes no register, returns `rdata` of 0 and raises `bad_access` for one cycle on the following edge.
- R4: A status write clears each bit written as 1 in the addressed bytes. Bits written as 0, and bytes not addressed, keep their value.
- R5: An enable write replaces the addressed bytes with the write data and leaves the other byte unchanged.
- R6: A control write merges the addressed bytes into the stored value. Bit 13 (sleep enable) is never stored and always reads back as 0.
- R7: With direct mode off, a control write whose merged bit 13 is 1 and whose merged bits 12:10 equal 1 produces `suspend_pulse` on the next edge. A value of 0 in bits 12:10 produces `poweroff_pulse` on the next edge.
- R8: With direct mode off, a sleep request with any other value in bits 12:10 produces neither action pulse and raises `sleep_type_err` for one cycle.
- R9: With direct mode on, every sleep request produces `poweroff_pulse` whatever bits 12:10 hold. That build never raises `suspend_pulse` or `sleep_type_err`.
- R10: `resume_in` sets status bit 15 on the next edge. When it coincides with a status write that clears bit 15, the bit ends up set.
- R11: The action and error pulses last exactly one cycle, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_off | input | ADDR_W | Byte offset of the access |
| io_size | input | 2 | Access width in bytes (valid: 1 or 2) |
| io_wdata | input | 16 | Write data, right-aligned |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| resume_in | input | 1 | Resume imminent; sets the wake flag |
| rdata | output | 16 | Registered read data |
| bad_access | output | 1 | One-cycle pulse for a rejected access |
| suspend_pulse | output | 1 | One-cycle suspend request |
| poweroff_pulse | output | 1 | One-cycle power-off request |
| sleep_type_err | output | 1 | One-cycle pulse for an unknown sleep type |

## Verification
A wrong stored register byte shows up only when software reads that register back. The bench therefore reads the registers often under random traffic, and it reads the target register directly after each rejected or partial write. That way a corrupted lane or an unwanted clear is caught within a few cycles rather than late in the run. Errors in the sleep decode show up at once on the action pulses, one edge after the control write. Running a second instance in direct mode alongside the first shows whether the forced power-off variant was selected.

// File: rtl/pm1_pkg.sv
package pm1_pkg;
  localparam int REG_W   = 16;
  localparam int LANES   = REG_W / 8;
  localparam int TYP_W   = 3;
  localparam int TYP_LSB = 10;
  localparam int SLPEN_BIT = 13;
  localparam int WAKE_BIT  = 15;
  localparam int MAP_BYTES = 6;

  typedef enum logic [1:0] {
    SEL_STAT = 2'd0,
    SEL_EN   = 2'd1,
    SEL_CTL  = 2'd2,
    SEL_NONE = 2'd3
  } pm1_sel_e;

  typedef struct packed {
    logic     ok;
    pm1_sel_e sel;
    logic     lane;
    logic [1:0] nbytes;
  } pm1_dec_t;

  function automatic logic [LANES-1:0] lane_enables(input logic lane, input logic [1:0] nbytes);
    if (nbytes == 2'd2) return '1;
    return lane ? 2'b10 : 2'b01;
  endfunction

  function automatic logic [REG_W-1:0] expand_lanes(input logic [LANES-1:0] be);
    logic [REG_W-1:0] m;
    for (int i = 0; i < LANES; i++) m[i*8 +: 8] = {8{be[i]}};
    return m;
  endfunction

  function automatic logic [REG_W-1:0] align_wr(input logic [REG_W-1:0] d, input logic lane);
    return lane ? {d[7:0], 8'h00} : d;
  endfunction

  function automatic logic [REG_W-1:0] extract_rd(input logic [REG_W-1:0] v, input logic lane,
                                                 input logic [1:0] nbytes);
    if (nbytes == 2'd2) return v;
    return {8'h00, (lane ? v[15:8] : v[7:0])};
  endfunction

  function automatic logic [REG_W-1:0] merge_lanes(input logic [REG_W-1:0] old_v,
                                                  input logic [REG_W-1:0] new_v,
                                                  input logic [REG_W-1:0] m);
    return (old_v & ~m) | (new_v & m);
  endfunction
endpackage

// File: rtl/pm1_addr_dec.sv
module pm1_addr_dec
  import pm1_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] off,
  input  logic [1:0]        size,
  output pm1_dec_t          dec
);
  logic       size_ok;
  logic       in_map;
  logic [2:0] span;
  logic       fits;

  always_comb begin
    size_ok = (size == 2'd1) || (size == 2'd2);
    in_map  = off < ADDR_W'(MAP_BYTES);
    span    = {2'b00, off[0]} + {1'b0, size};
    fits    = span <= 3'd2;
    dec.ok     = size_ok && in_map && fits;
    dec.lane   = off[0];
    dec.nbytes = size;
    dec.sel    = dec.ok ? pm1_sel_e'(off[2:1]) : SEL_NONE;
  end

  initial begin
    if (ADDR_W < 3) $error("ADDR_W must cover the register map");
  end
endmodule

// File: rtl/pm1_sleep_dec.sv
module pm1_sleep_dec
  import pm1_pkg::*;
#(
  parameter bit              DIRECT_MODE = 1'b0,
  parameter logic [TYP_W-1:0] SUSP_CODE  = 3'd1,
  parameter logic [TYP_W-1:0] OFF_CODE   = 3'd0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [TYP_W-1:0] typ,
  output logic             suspend_o,
  output logic             poweroff_o,
  output logic             type_err_o
);
  logic want_susp, want_off, want_err;

  generate
    if (DIRECT_MODE) begin : g_direct
      always_comb begin
        want_susp = 1'b0;
        want_off  = req;
        want_err  = 1'b0;
      end
      // R9: a direct-mode request always ends in power-off
      p_direct_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> poweroff_o && !suspend_o);
    end else begin : g_typed
      always_comb begin
        want_susp = req && (typ == SUSP_CODE);
        want_off  = req && (typ == OFF_CODE);
        want_err  = req && (typ != SUSP_CODE) && (typ != OFF_CODE);
      end
      // R8: an unknown type raises the error and no action
      p_unknown_type_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req && typ != SUSP_CODE && typ != OFF_CODE) |=> type_err_o && !suspend_o && !poweroff_o);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      suspend_o  <= 1'b0;
      poweroff_o <= 1'b0;
      type_err_o <= 1'b0;
    end else begin
      suspend_o  <= want_susp;
      poweroff_o <= want_off;
      type_err_o <= want_err;
    end
  end

  // R11: never two outcome pulses together
  p_one_outcome_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({suspend_o, poweroff_o, type_err_o}));
endmodule

// File: rtl/pm1_regblk.sv
module pm1_regblk
  import pm1_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter bit DIRECT_MODE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_off,
  input  logic [1:0]        io_size,
  input  logic [15:0]       io_wdata,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic              resume_in,
  output logic [15:0]       rdata,
  output logic              bad_access,
  output logic              suspend_pulse,
  output logic              poweroff_pulse,
  output logic              sleep_type_err
);
  pm1_dec_t         dec;
  logic             bad_req, wr_hit, rd_hit;
  logic             stat_wr, en_wr, ctl_wr, sleep_req;
  logic [LANES-1:0] byte_en;
  logic [REG_W-1:0] bit_en, wd_al, stat_clr, ctl_merged, cur_val;
  logic [REG_W-1:0] stat_q, en_q, ctl_q;

  pm1_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .off (io_off),
    .size(io_size),
    .dec (dec)
  );

  always_comb begin
    bad_req   = (io_wr || io_rd) && !dec.ok;
    wr_hit    = io_wr && dec.ok;
    rd_hit    = io_rd && dec.ok;
    stat_wr   = wr_hit && (dec.sel == SEL_STAT);
    en_wr     = wr_hit && (dec.sel == SEL_EN);
    ctl_wr    = wr_hit && (dec.sel == SEL_CTL);
    byte_en   = lane_enables(dec.lane, dec.nbytes);
    bit_en    = expand_lanes(byte_en);
    wd_al     = align_wr(io_wdata, dec.lane);
    stat_clr  = stat_wr ? (bit_en & wd_al) : '0;
    ctl_merged = merge_lanes(ctl_q, wd_al, bit_en);
    sleep_req = ctl_wr && ctl_merged[SLPEN_BIT];
    unique case (dec.sel)
      SEL_STAT: cur_val = stat_q;
      SEL_EN:   cur_val = en_q;
      SEL_CTL:  cur_val = ctl_q;
      default:  cur_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q     <= '0;
      en_q       <= '0;
      ctl_q      <= '0;
      rdata      <= '0;
      bad_access <= 1'b0;
    end else begin
      stat_q <= (stat_q & ~stat_clr) | (resume_in ? (REG_W'(1) << WAKE_BIT) : '0);
      if (en_wr)  en_q  <= merge_lanes(en_q, wd_al, bit_en);
      if (ctl_wr) ctl_q <= ctl_merged & ~(REG_W'(1) << SLPEN_BIT);
      rdata      <= rd_hit ? extract_rd(cur_val, dec.lane, dec.nbytes) : '0;
      bad_access <= bad_req;
    end
  end

  pm1_sleep_dec #(.DIRECT_MODE(DIRECT_MODE)) u_sleep (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (sleep_req),
    .typ       (ctl_merged[TYP_LSB +: TYP_W]),
    .suspend_o (suspend_pulse),
    .poweroff_o(poweroff_pulse),
    .type_err_o(sleep_type_err)
  );

  // R3: a rejected access leaves enable and control untouched
  p_bad_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_req && !resume_in) |=> $stable(en_q) && $stable(ctl_q) && $stable(stat_q));
  // R3: a rejected access is flagged and reads zero
  p_bad_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bad_req |=> bad_access && (rdata == '0));
  // R10: resume always wins the wake bit
  p_wake_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    resume_in |=> stat_q[WAKE_BIT]);
  // R7: a suspend pulse only follows a sleep request
  p_suspend_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_pulse |-> $past(sleep_req));
  // R6: the sleep-enable bit is not kept after a control write
  p_slpen_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> !ctl_q[SLPEN_BIT]);
endmodule

// File: tb/tb_pm1_regblk.sv
`timescale 1ns/1ps
module tb_pm1_regblk;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  io_off = '0;
  logic [1:0]  io_size = '0;
  logic [15:0] io_wdata = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0, resume_in = 1'b0;
  logic [15:0] rdata, rdata_dm;
  logic        bad_access, suspend_pulse, poweroff_pulse, sleep_type_err;
  logic        bad_dm, susp_dm, off_dm, err_dm;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [15:0] m_st = '0, m_en = '0, m_ct = '0;

  always #4 clk = ~clk;

  pm1_regblk #(.ADDR_W(4), .DIRECT_MODE(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .io_off(io_off), .io_size(io_size), .io_wdata(io_wdata),
    .io_wr(io_wr), .io_rd(io_rd), .resume_in(resume_in), .rdata(rdata),
    .bad_access(bad_access), .suspend_pulse(suspend_pulse),
    .poweroff_pulse(poweroff_pulse), .sleep_type_err(sleep_type_err));

  pm1_regblk #(.ADDR_W(4), .DIRECT_MODE(1'b1)) dut_dm (
    .clk(clk), .rst_n(rst_n), .io_off(io_off), .io_size(io_size), .io_wdata(io_wdata),
    .io_wr(io_wr), .io_rd(io_rd), .resume_in(resume_in), .rdata(rdata_dm),
    .bad_access(bad_dm), .suspend_pulse(susp_dm),
    .poweroff_pulse(off_dm), .sleep_type_err(err_dm));

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic bit legal(input int off, input int sz);
    return (sz == 1 || sz == 2) && off < 6 && ((off % 2) + sz) <= 2;
  endfunction

  function automatic logic [15:0] model_reg(input int idx);
    if (idx == 0) return m_st;
    if (idx == 1) return m_en;
    return m_ct;
  endfunction

  // one access; expected values derived byte by byte from the requirements
  task automatic acc(input bit w, input bit r, input int off, input int sz,
                     input logic [15:0] d, input bit res, input string tag);
    bit ok = legal(off, sz);
    int ln = off % 2;
    int idx = off / 2;
    logic [15:0] e_rd = '0, cur;
    bit e_su = 0, e_po = 0, e_er = 0, e_po_dm = 0;
    if (ok) begin
      cur = model_reg(idx);
      if (r) e_rd = (sz == 2) ? cur : ((cur >> (8 * ln)) & 16'h00FF);
      if (w) begin
        for (int b = ln; b < ln + sz; b++) begin
          logic [7:0] db = d[8*(b-ln) +: 8];
          if (idx == 0) cur[8*b +: 8] = cur[8*b +: 8] & ~db;
          else          cur[8*b +: 8] = db;
        end
        if (idx == 0) m_st = cur;
        if (idx == 1) m_en = cur;
        if (idx == 2) begin
          if (cur[13]) begin
            e_po_dm = 1;
            case (cur[12:10])
              3'd1: e_su = 1;
              3'd0: e_po = 1;
              default: e_er = 1;
            endcase
          end
          m_ct = cur & 16'hDFFF;
        end
      end
    end
    if (res) m_st = m_st | 16'h8000;
    io_off = 4'(off); io_size = 2'(sz); io_wdata = d;
    io_wr = w; io_rd = r; resume_in = res;
    @(negedge clk);
    chk({tag, " rdata"}, rdata, e_rd);
    chk({tag, " bad"}, 16'(bad_access), 16'((w || r) && !ok));
    chk({tag, " suspend"}, 16'(suspend_pulse), 16'(e_su));
    chk({tag, " poweroff"}, 16'(poweroff_pulse), 16'(e_po));
    chk({tag, " typeerr"}, 16'(sleep_type_err), 16'(e_er));
    chk({tag, " R9 direct poweroff"}, 16'(off_dm), 16'(e_po_dm));
    chk({tag, " R9 direct quiet"}, 16'({susp_dm, err_dm}), 16'd0);
    chk({tag, " R9 direct rdata"}, rdata_dm, e_rd);
    io_wr = 0; io_rd = 0; resume_in = 0;
  endtask

  task automatic idle_pulse_chk();
    @(negedge clk);
    chk("R11 pulses single cycle", 16'({suspend_pulse, poweroff_pulse, sleep_type_err, off_dm}), 16'd0);
  endtask

  task automatic read_all(input string tag);
    for (int i = 0; i < 3; i++) acc(0, 1, 2 * i, 2, 16'h0, 0, tag);
  endtask

  initial begin
    #(8ns * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20211220);
    repeat (3) @(negedge clk);
    chk("R1 reset rdata", rdata, 16'h0);
    chk("R1 reset pulses", 16'({bad_access, suspend_pulse, poweroff_pulse, sleep_type_err}), 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    read_all("R1 reset regs");

    acc(1, 0, 2, 2, 16'hA55A, 0, "R5 enable word");
    acc(0, 1, 3, 1, 16'h0, 0, "R2 enable high byte");
    acc(1, 0, 3, 1, 16'h00C3, 0, "R5 enable high byte write");
    acc(0, 1, 2, 2, 16'h0, 0, "R5 enable readback");
    acc(1, 0, 2, 1, 16'hFF11, 0, "R5 enable low byte write");
    acc(0, 1, 2, 2, 16'h0, 0, "R2 enable word read");

    acc(1, 0, 3, 2, 16'hFFFF, 0, "R3 crossing write");
    acc(1, 0, 2, 3, 16'hFFFF, 0, "R3 size three");
    acc(1, 0, 2, 0, 16'hFFFF, 0, "R3 size zero");
    acc(0, 1, 6, 1, 16'h0, 0, "R3 unmapped read");
    acc(1, 0, 7, 1, 16'hFFFF, 0, "R3 unmapped write");
    read_all("R3 regs unchanged");

    acc(0, 0, 0, 1, 16'h0, 1, "R10 resume");
    acc(0, 1, 1, 1, 16'h0, 0, "R10 wake high byte");
    acc(1, 0, 0, 1, 16'h00FF, 0, "R4 clear wrong lane");
    acc(0, 1, 0, 2, 16'h0, 0, "R4 wake kept");
    acc(1, 0, 0, 2, 16'h8000, 1, "R10 resume beats clear");
    acc(0, 1, 0, 2, 16'h0, 0, "R10 wake still set");
    acc(1, 0, 1, 1, 16'h0080, 0, "R4 clear wake");
    acc(0, 1, 0, 2, 16'h0, 0, "R4 status cleared");

    acc(1, 0, 4, 2, 16'h2400, 0, "R7 suspend request");
    idle_pulse_chk();
    acc(0, 1, 4, 2, 16'h0, 0, "R6 slpen reads zero");
    acc(1, 0, 4, 2, 16'h2000, 0, "R7 poweroff request");
    idle_pulse_chk();
    acc(1, 0, 4, 2, 16'h2800, 0, "R8 type two");
    idle_pulse_chk();
    acc(1, 0, 4, 2, 16'h3C00, 0, "R8 type seven");
    acc(1, 0, 4, 2, 16'h0401, 0, "R6 set type one");
    acc(1, 0, 5, 1, 16'h0024, 0, "R7 high byte sleep uses merged type");
    acc(0, 1, 4, 2, 16'h0, 0, "R6 merged readback");

    for (int i = 0; i < 600; i++) begin
      int off = $urandom_range(0, 7);
      int sz  = $urandom_range(0, 3);
      bit w   = $urandom_range(0, 1) == 1;
      bit res = $urandom_range(0, 9) == 0;
      logic [15:0] d = 16'($urandom);
      acc(w, !w, off, sz, d, res, "R2 random");
    end
    read_all("R2 final regs");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule